// File: doc/BRIEF.md
# Synchronous Slotted Ring Node

This block is one station on a one-way ring of identical stations that all run from one shared clock. Each station takes a wide parallel slot from its upstream neighbour and hands a wide parallel slot to its downstream neighbour. A slot holds a valid flag, a pattern field that tags the kind of data, and a data word. Each field bit travels on its own conductor.

A local phase counter runs through `NODES` values. Every station's counter leaves reset at zero, so all stations inject together on phase zero. On that phase the incoming slot is the station's own message from the previous round. That message has visited every other station, so the station drops it and loads a fresh local message from a request/accept handshake. If no request is pending, it sends an empty slot.

On the other `NODES-1` phases the station passes the incoming slot on unchanged. It also shows a copy to a local receive tap, and the tap reports which station the message came from. Because every station owns one slot in every round, no arbitration is needed and each station's share of the ring is fixed.

Top module: `ring_node`

## Requirements
- R1: A synchronous active-low reset empties the outgoing slot (valid, pattern and data all zero) and sets the phase counter to zero. The first cycle with reset released is therefore an injection cycle.
- R2: Injection cycles fall on the first cycle after reset and then on every `NODES`-th cycle. `tx_ack` equals `tx_req` on an injection cycle and is 0 on every other cycle.
- R3: When `tx_req` is 1 on an injection cycle, the outgoing slot one cycle later has valid 1 and carries `tx_pat` and `tx_data`.
- R4: When `tx_req` is 0 on an injection cycle, the outgoing slot one cycle later is empty: valid, pattern and data are all 0.
- R5: On an injection cycle the incoming slot is dropped. `rx_valid` is 0 in that cycle, and the incoming slot does not appear downstream.
- R6: On a non-injection cycle, the outgoing slot one cycle later equals the incoming slot bit for bit, empty slots included. Each hop adds exactly one cycle.
- R7: On a non-injection cycle the receive tap shows the incoming slot in the same cycle. `rx_valid` equals `up_valid`, and when it is 1, `rx_pat` and `rx_data` equal `up_pat` and `up_data`.
- R8: On a non-injection cycle that lies c cycles after the last injection cycle, `rx_src` equals (`NODE_IDX` − c) mod `NODES`. This is the index of the station that injected the message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common ring clock |
| rst_n | input | 1 | Synchronous reset, active low |
| up_valid | input | 1 | Incoming slot occupied |
| up_pat | input | PAT_W | Incoming pattern field |
| up_data | input | DATA_W | Incoming data word |
| tx_req | input | 1 | Local message waiting to be sent |
| tx_pat | input | PAT_W | Pattern of the local message |
| tx_data | input | DATA_W | Data of the local message |
| tx_ack | output | 1 | Local message taken this cycle |
| dn_valid | output | 1 | Outgoing slot occupied (registered) |
| dn_pat | output | PAT_W | Outgoing pattern field (registered) |
| dn_data | output | DATA_W | Outgoing data word (registered) |
| rx_valid | output | 1 | Receive tap holds a message from another station |
| rx_pat | output | PAT_W | Pattern seen by the receive tap |
| rx_data | output | DATA_W | Data seen by the receive tap |
| rx_src | output | CNT_W | Index of the station that sent the tapped message |

## Verification
The hardest case to reach is the returning-message discard. An occupied upstream slot must land exactly on the injection phase, and it must land there while a local request is both present and absent. Otherwise the checks of R4 and R5 cannot be told apart from ordinary forwarding.

To reach it, the stimulus holds `up_valid` high through whole rounds while the request pattern alternates between always-on, always-off and random. The bench also applies a reset in the middle of a round, which realigns the phase to zero from an odd position. A behavioural model keeps its own phase count and compares the tap, the handshake and the delayed outgoing slot on every clock.

// File: rtl/ring_pkg.sv
// Package ring_pkg
// Shared helpers for the slotted ring station.
// Assumes the station count is at least two.
package ring_pkg;

    // Index of the station whose message arrives after `hops` hops at `node`.
    function automatic int unsigned origin_of(input int unsigned node,
                                              input int unsigned hops,
                                              input int unsigned nodes);
        if (hops <= node)
            return node - hops;
        else
            return node + nodes - hops;
    endfunction

endpackage

// File: rtl/slot_timer.sv
// Module slot_timer
// Phase counter that cycles 0 .. NODES-1 and restarts at 0.
// Phase 0 is the injection phase, shared by every station on the ring.
// The module also gives the origin index of the slot arriving in the current phase.
// Assumes NODES >= 2 and NODE_IDX < NODES.
module slot_timer #(
    parameter int NODES    = 4,
    parameter int NODE_IDX = 0,
    parameter int CNT_W    = (NODES > 1) ? $clog2(NODES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             inject,
    output logic [CNT_W-1:0] origin
);
    import ring_pkg::*;

    localparam logic [CNT_W-1:0] LAST = CNT_W'(NODES - 1);

    logic [CNT_W-1:0] phase_q;

    // Purpose: advance the phase every clock and wrap after the last station.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (phase_q == LAST)
            phase_q <= '0;
        else
            phase_q <= phase_q + 1'b1;
    end

    // Purpose: flag the injection phase and derive the origin of the arriving slot.
    always_comb begin
        inject = (phase_q == '0);
        origin = CNT_W'(origin_of(NODE_IDX, int'(phase_q), NODES));
    end

endmodule

// File: rtl/slot_stage.sv
// Module slot_stage
// Output register of the station.
// On the injection phase it loads the local message, or an empty slot if no
// request is pending. On every other phase it copies the upstream slot.
// Assumes inject comes from the shared phase counter.
module slot_stage #(
    parameter int DATA_W = 256,
    parameter int PAT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inject,
    input  logic              up_valid,
    input  logic [PAT_W-1:0]  up_pat,
    input  logic [DATA_W-1:0] up_data,
    input  logic              tx_req,
    input  logic [PAT_W-1:0]  tx_pat,
    input  logic [DATA_W-1:0] tx_data,
    output logic              dn_valid,
    output logic [PAT_W-1:0]  dn_pat,
    output logic [DATA_W-1:0] dn_data
);

    // Purpose: register the outgoing slot, choosing local or forwarded content.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dn_valid <= 1'b0;
            dn_pat   <= '0;
            dn_data  <= '0;
        end else if (inject) begin
            dn_valid <= tx_req;
            dn_pat   <= tx_req ? tx_pat  : '0;
            dn_data  <= tx_req ? tx_data : '0;
        end else begin
            dn_valid <= up_valid;
            dn_pat   <= up_pat;
            dn_data  <= up_data;
        end
    end

endmodule

// File: rtl/rx_tap.sv
// Module rx_tap
// Combinational receive tap. It shows the upstream slot to the local side,
// except on the injection phase, when the slot is the station's own returning
// message. The origin index is passed through alongside.
module rx_tap #(
    parameter int DATA_W = 256,
    parameter int PAT_W  = 16,
    parameter int CNT_W  = 2
) (
    input  logic              inject,
    input  logic              up_valid,
    input  logic [PAT_W-1:0]  up_pat,
    input  logic [DATA_W-1:0] up_data,
    input  logic [CNT_W-1:0]  origin,
    output logic              rx_valid,
    output logic [PAT_W-1:0]  rx_pat,
    output logic [DATA_W-1:0] rx_data,
    output logic [CNT_W-1:0]  rx_src
);

    // Purpose: qualify the tap and suppress the returning message.
    always_comb begin
        rx_valid = up_valid && !inject;
        rx_pat   = up_pat;
        rx_data  = up_data;
        rx_src   = origin;
    end

endmodule

// File: rtl/ring_node.sv
// Module ring_node
// One station of a synchronous, unidirectional slotted ring.
// Every station injects on the same shared phase. A slot then moves one
// station per clock for NODES-1 cycles and returns to its sender, which drops it.
// Assumes NODES >= 2, NODE_IDX < NODES, and all stations reset together.
module ring_node #(
    parameter int DATA_W   = 256,
    parameter int PAT_W    = 16,
    parameter int NODES    = 4,
    parameter int NODE_IDX = 0,
    parameter int CNT_W    = (NODES > 1) ? $clog2(NODES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_valid,
    input  logic [PAT_W-1:0]  up_pat,
    input  logic [DATA_W-1:0] up_data,
    input  logic              tx_req,
    input  logic [PAT_W-1:0]  tx_pat,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_ack,
    output logic              dn_valid,
    output logic [PAT_W-1:0]  dn_pat,
    output logic [DATA_W-1:0] dn_data,
    output logic              rx_valid,
    output logic [PAT_W-1:0]  rx_pat,
    output logic [DATA_W-1:0] rx_data,
    output logic [CNT_W-1:0]  rx_src
);

    logic             inject;
    logic [CNT_W-1:0] origin;

    slot_timer #(
        .NODES    (NODES),
        .NODE_IDX (NODE_IDX),
        .CNT_W    (CNT_W)
    ) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .inject (inject),
        .origin (origin)
    );

    slot_stage #(
        .DATA_W (DATA_W),
        .PAT_W  (PAT_W)
    ) i_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .inject   (inject),
        .up_valid (up_valid),
        .up_pat   (up_pat),
        .up_data  (up_data),
        .tx_req   (tx_req),
        .tx_pat   (tx_pat),
        .tx_data  (tx_data),
        .dn_valid (dn_valid),
        .dn_pat   (dn_pat),
        .dn_data  (dn_data)
    );

    rx_tap #(
        .DATA_W (DATA_W),
        .PAT_W  (PAT_W),
        .CNT_W  (CNT_W)
    ) i_tap (
        .inject   (inject),
        .up_valid (up_valid),
        .up_pat   (up_pat),
        .up_data  (up_data),
        .origin   (origin),
        .rx_valid (rx_valid),
        .rx_pat   (rx_pat),
        .rx_data  (rx_data),
        .rx_src   (rx_src)
    );

    // Purpose: accept the local message only in the shared injection slot.
    always_comb tx_ack = inject && tx_req;

endmodule

// File: rtl/ring_node_chk.sv
// Module ring_node_chk
// Checker bound to ring_node. It keeps its own phase count from reset and
// checks the handshake, the tap and the outgoing slot against that count.
module ring_node_chk #(
    parameter int DATA_W = 256,
    parameter int PAT_W  = 16,
    parameter int NODES  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              up_valid,
    input logic [PAT_W-1:0]  up_pat,
    input logic [DATA_W-1:0] up_data,
    input logic              tx_req,
    input logic [PAT_W-1:0]  tx_pat,
    input logic [DATA_W-1:0] tx_data,
    input logic              tx_ack,
    input logic              dn_valid,
    input logic [PAT_W-1:0]  dn_pat,
    input logic [DATA_W-1:0] dn_data,
    input logic              rx_valid,
    input logic [PAT_W-1:0]  rx_pat,
    input logic [DATA_W-1:0] rx_data
);

    int unsigned ph;

    // Purpose: independent phase count used by the properties below.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ph <= 0;
        else if (ph == NODES - 1)
            ph <= 0;
        else
            ph <= ph + 1;
    end

    a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!dn_valid && dn_pat == '0 && dn_data == '0));

    a_r2_ack_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ack |-> (ph == 0));

    a_r2_ack_when_asked: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == 0 && tx_req) |-> tx_ack);

    a_r3_load_local: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == 0 && tx_req) |=> (dn_valid && dn_pat == $past(tx_pat) && dn_data == $past(tx_data)));

    a_r4_empty_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == 0 && !tx_req) |=> (!dn_valid && dn_pat == '0 && dn_data == '0));

    a_r5_drop_own: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == 0) |-> !rx_valid);

    a_r6_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (ph != 0) |=> (dn_valid == $past(up_valid) && dn_pat == $past(up_pat)
                       && dn_data == $past(up_data)));

    a_r7_tap_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (ph != 0) |-> (rx_valid == up_valid
                       && (!up_valid || (rx_pat == up_pat && rx_data == up_data))));

endmodule

bind ring_node ring_node_chk #(
    .DATA_W (DATA_W),
    .PAT_W  (PAT_W),
    .NODES  (NODES)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (up_valid),
    .up_pat   (up_pat),
    .up_data  (up_data),
    .tx_req   (tx_req),
    .tx_pat   (tx_pat),
    .tx_data  (tx_data),
    .tx_ack   (tx_ack),
    .dn_valid (dn_valid),
    .dn_pat   (dn_pat),
    .dn_data  (dn_data),
    .rx_valid (rx_valid),
    .rx_pat   (rx_pat),
    .rx_data  (rx_data)
);

// File: tb/test_ring_node.sv
// Bench for ring_node. A behavioural phase model predicts the handshake,
// the tap and the one-cycle-delayed outgoing slot, and compares them every clock.
module test_ring_node;
    localparam int CLK_PERIOD = 10;
    localparam int DW  = 64;
    localparam int PW  = 8;
    localparam int NN  = 4;
    localparam int IDX = 2;
    localparam int CW  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic          up_valid = 1'b0;
    logic [PW-1:0] up_pat   = '0;
    logic [DW-1:0] up_data  = '0;
    logic          tx_req   = 1'b0;
    logic [PW-1:0] tx_pat   = '0;
    logic [DW-1:0] tx_data  = '0;
    logic          tx_ack, dn_valid, rx_valid;
    logic [PW-1:0] dn_pat, rx_pat;
    logic [DW-1:0] dn_data, rx_data;
    logic [CW-1:0] rx_src;

    ring_node #(.DATA_W(DW), .PAT_W(PW), .NODES(NN), .NODE_IDX(IDX)) i_ring_node (
        .clk(clk), .rst_n(rst_n),
        .up_valid(up_valid), .up_pat(up_pat), .up_data(up_data),
        .tx_req(tx_req), .tx_pat(tx_pat), .tx_data(tx_data), .tx_ack(tx_ack),
        .dn_valid(dn_valid), .dn_pat(dn_pat), .dn_data(dn_data),
        .rx_valid(rx_valid), .rx_pat(rx_pat), .rx_data(rx_data), .rx_src(rx_src)
    );

    int total = 0;
    int bad   = 0;

    // Model state
    int            phase = 0;
    bit            exp_known = 0;
    logic          exp_v;
    logic [PW-1:0] exp_p;
    logic [DW-1:0] exp_d;
    string         exp_req = "R1";

    task automatic check_eq(input string req, input string what,
                            input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // mode 0: request always, upstream always full
    // mode 1: no request, upstream always full
    // mode 2: random both
    // mode 3: request random, upstream always empty
    task automatic drive(input int mode);
        up_pat  = PW'($urandom);
        up_data = {$urandom, $urandom};
        tx_pat  = PW'($urandom);
        tx_data = {$urandom, $urandom};
        case (mode)
            0: begin tx_req = 1'b1; up_valid = 1'b1; end
            1: begin tx_req = 1'b0; up_valid = 1'b1; end
            2: begin tx_req = 1'($urandom); up_valid = 1'($urandom); end
            default: begin tx_req = 1'($urandom); up_valid = 1'b0; end
        endcase
    endtask

    task automatic step(input int mode, input bit in_reset);
        bit inj;
        @(negedge clk);
        rst_n = !in_reset;
        drive(mode);
        #1;
        if (exp_known) begin
            check_eq(exp_req, "dn_valid", DW'(dn_valid), DW'(exp_v));
            check_eq(exp_req, "dn_pat",   DW'(dn_pat),   DW'(exp_p));
            check_eq(exp_req, "dn_data",  dn_data,       exp_d);
        end
        inj = (phase == 0);
        if (!in_reset) begin
            check_eq("R2", "tx_ack", DW'(tx_ack), DW'(inj && tx_req));
            if (inj) begin
                check_eq("R5", "rx_valid", DW'(rx_valid), DW'(0));
            end else begin
                check_eq("R7", "rx_valid", DW'(rx_valid), DW'(up_valid));
                if (up_valid) begin
                    check_eq("R7", "rx_pat",  DW'(rx_pat), DW'(up_pat));
                    check_eq("R7", "rx_data", rx_data,     up_data);
                end
                check_eq("R8", "rx_src", DW'(rx_src), DW'((IDX - phase + NN) % NN));
            end
        end
        // predict the next cycle
        if (in_reset) begin
            phase = 0; exp_v = 1'b0; exp_p = '0; exp_d = '0; exp_req = "R1";
        end else if (inj) begin
            exp_v = tx_req;
            exp_p = tx_req ? tx_pat : '0;
            exp_d = tx_req ? tx_data : '0;
            exp_req = tx_req ? "R3" : "R4";
            phase = 1 % NN;
        end else begin
            exp_v = up_valid; exp_p = up_pat; exp_d = up_data;
            exp_req = "R6";
            phase = (phase + 1) % NN;
        end
        exp_known = 1;
    endtask

    initial begin
        // watchdog: counts as a failed check and still prints the summary
        #(CLK_PERIOD * 200000);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset for a few cycles, then the first released cycle injects
        for (int i = 0; i < 3; i++) step(2, 1'b1);
        for (int i = 0; i < 40; i++) step(0, 1'b0);    // R3, R5 with full upstream
        for (int i = 0; i < 40; i++) step(1, 1'b0);    // R4, R5 with full upstream
        for (int i = 0; i < 41; i++) step(2, 1'b0);    // random, odd length
        step(2, 1'b1);                                  // R1: reset mid-round
        step(2, 1'b1);
        for (int i = 0; i < 40; i++) step(3, 1'b0);    // R6: empty slots forwarded
        for (int i = 0; i < 300; i++) step(2, 1'b0);   // R2, R6, R7, R8 random
        @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule